// File: doc/BRIEF.md
# Seat-Belt Warning Alarm Controller

This controller raises a warning when the ignition key has been switched on and the driver has not buckled up in time. It watches three single-cycle event pulses: key switched on, key switched off and belt fastened. It counts pulses of a tick enable, for example one per second, from the moment the key is switched on. The alarm window opens after a first delay and closes after a second, longer delay. Both delays are measured from the key-on event.

Switching the key off or fastening the belt ends the sequence at any point and silences the alarm. The active-low asynchronous reset overrides everything. Each accepted key-on event restarts the sequence and issues a one-cycle timer-start indication. Tick generation, debouncing and tone generation are handled outside the block.

Top module: `seatbelt_warn`

## Requirements
- R1: While rst_ni is low, alarm_o and start_timer_o are low. After reset is released they stay low until a key-on event is accepted.
- R2: A key_on_i pulse with key_off_i and belt_on_i both low is accepted. start_timer_o is then high for exactly the following cycle, and the tick count restarts from zero.
- R3: alarm_o goes high in the cycle after the edge that samples the DELAY_ON-th tick_i pulse following an accepted key-on. A tick sampled at the same edge as the key-on is not counted.
- R4: alarm_o goes low in the cycle after the edge that samples the DELAY_OFF-th tick_i pulse, counted from the same key-on. The controller then idles, and further ticks leave alarm_o low.
- R5: A key_off_i or belt_on_i pulse ends the sequence. alarm_o is low from the next cycle, and later ticks do not raise it.
- R6: If an abort pulse arrives in the same cycle as the DELAY_ON-th tick, the abort wins and alarm_o stays low.
- R7: A key-on accepted during an active sequence drops alarm_o in the next cycle. It then requires a full DELAY_ON ticks again before alarm_o rises.
- R8: A key_on_i pulse in the same cycle as key_off_i or belt_on_i is not accepted. No start_timer_o pulse follows, and no alarm follows.
- R9: While idle, tick_i, key_off_i and belt_on_i pulses have no effect on either output.
- R10: Asserting rst_ni mid-sequence drops alarm_o at once. After release, ticks do not raise alarm_o until a new key-on is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base enable pulse counted by the delay timer |
| key_on_i | input | 1 | Key switched on event, one cycle |
| key_off_i | input | 1 | Key switched off event, one cycle |
| belt_on_i | input | 1 | Belt fastened event, one cycle |
| alarm_o | output | 1 | Warning level output |
| start_timer_o | output | 1 | One-cycle pulse after an accepted key-on |

## Verification
The bench counts ticks to the exact cycle at both window edges. An off-by-one timer would raise or drop the alarm one tick early or late. A design that counted the tick arriving with key-on would fire one tick early. The bench places an abort on the very tick that would open the window; a design giving expiry priority would sound briefly. The bench also sends a key-on during the alarm and a key-on together with an abort. These catch a restart that keeps the old count or keeps the alarm, and a key-on that overrides the abort.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_ALERT = 2'd2
  } sbw_state_e;
endpackage

// File: rtl/sbw_delay_timer.sv
module sbw_delay_timer #(
  parameter int unsigned DELAY_ON  = 5,
  parameter int unsigned DELAY_OFF = 10,
  localparam int unsigned CW = $clog2(DELAY_OFF + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  input  logic tick_i,
  output logic hit_on_o,
  output logic hit_off_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clear_i)               cnt_q <= '0;
    else if (run_i && tick_i)       cnt_q <= cnt_q + 1'b1;
  end

  // hit on the tick that completes each delay
  assign hit_on_o  = run_i && tick_i && (cnt_q == CW'(DELAY_ON - 1));
  assign hit_off_o = run_i && tick_i && (cnt_q == CW'(DELAY_OFF - 1));

  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DELAY_OFF));
endmodule

// File: rtl/sbw_sequencer.sv
module sbw_sequencer
  import sbw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic key_on_i,
  input  logic key_off_i,
  input  logic belt_on_i,
  input  logic hit_on_i,
  input  logic hit_off_i,
  output logic clear_o,
  output logic run_o,
  output logic alarm_o,
  output logic start_timer_o
);
  sbw_state_e state_q, state_d;
  logic abort, start;

  assign abort = key_off_i | belt_on_i;
  assign start = key_on_i & ~abort;

  always_comb begin
    state_d = state_q;
    if (abort)      state_d = ST_IDLE;
    else if (start) state_d = ST_ARMED;
    else begin
      unique case (state_q)
        ST_ARMED: if (hit_on_i)  state_d = ST_ALERT;
        ST_ALERT: if (hit_off_i) state_d = ST_IDLE;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      start_timer_o <= 1'b0;
    end else begin
      state_q       <= state_d;
      start_timer_o <= start;
    end
  end

  assign clear_o = start;
  assign run_o   = (state_q != ST_IDLE);
  assign alarm_o = (state_q == ST_ALERT);

  // R1
  a_r1_quiet_in_reset: assert property (@(posedge clk_i)
    !rst_ni |-> (!alarm_o && !start_timer_o));
  a_r2_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_on_i && !key_off_i && !belt_on_i) |=> start_timer_o);
  a_r3_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_o) |-> $past(tick_i));
  a_r5_abort_silences: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_off_i || belt_on_i) |=> (!alarm_o && !run_o));
  a_r7_restart_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_on_i && !key_off_i && !belt_on_i) |=> !alarm_o);
  a_r8_no_start_on_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_on_i && (key_off_i || belt_on_i)) |=> !start_timer_o);
endmodule

// File: rtl/seatbelt_warn.sv
module seatbelt_warn #(
  parameter int unsigned DELAY_ON  = 5,
  parameter int unsigned DELAY_OFF = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic key_on_i,
  input  logic key_off_i,
  input  logic belt_on_i,
  output logic alarm_o,
  output logic start_timer_o
);
  logic clear, run, hit_on, hit_off;

  sbw_sequencer i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .key_on_i     (key_on_i),
    .key_off_i    (key_off_i),
    .belt_on_i    (belt_on_i),
    .hit_on_i     (hit_on),
    .hit_off_i    (hit_off),
    .clear_o      (clear),
    .run_o        (run),
    .alarm_o      (alarm_o),
    .start_timer_o(start_timer_o)
  );

  sbw_delay_timer #(
    .DELAY_ON (DELAY_ON),
    .DELAY_OFF(DELAY_OFF)
  ) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear),
    .run_i    (run),
    .tick_i   (tick_i),
    .hit_on_o (hit_on),
    .hit_off_o(hit_off)
  );
endmodule

// File: tb/test_seatbelt_warn.sv
module test_seatbelt_warn;
  localparam int CLK_PERIOD = 10;
  localparam int D_ON  = 5;
  localparam int D_OFF = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick, kon, koff, belt;
  logic alarm, start;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seatbelt_warn #(.DELAY_ON(D_ON), .DELAY_OFF(D_OFF)) i_seatbelt_warn (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .key_on_i(kon),
    .key_off_i(koff), .belt_on_i(belt), .alarm_o(alarm), .start_timer_o(start)
  );

  task automatic check(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // one clock with given pulses; outputs settle 1 time unit after the edge
  task automatic step(input logic k_on, input logic k_off, input logic b_on, input logic tk);
    kon = k_on; koff = k_off; belt = b_on; tick = tk;
    @(posedge clk); #1;
    kon = 0; koff = 0; belt = 0; tick = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1);
  endtask

  task automatic t_reset;
    check("R1 alarm in reset", alarm, 1'b0);
    check("R1 start in reset", start, 1'b0);
    rst_ni = 1'b1;
    step(0, 0, 0, 0);
    ticks(D_OFF + 2);
    check("R1 alarm after release", alarm, 1'b0);
    check("R1 start after release", start, 1'b0);
  endtask

  task automatic t_full_window;
    step(1, 0, 0, 0);
    check("R2 start pulse", start, 1'b1);
    check("R2 alarm low at start", alarm, 1'b0);
    step(0, 0, 0, 0);
    check("R2 start one cycle", start, 1'b0);
    ticks(D_ON - 1);
    check("R3 before first delay", alarm, 1'b0);
    ticks(1);
    check("R3 alarm on first delay", alarm, 1'b1);
    step(0, 0, 0, 0);
    check("R3 alarm holds without tick", alarm, 1'b1);
    ticks(D_OFF - D_ON - 1);
    check("R4 alarm before second delay", alarm, 1'b1);
    ticks(1);
    check("R4 alarm off at second delay", alarm, 1'b0);
    ticks(D_OFF);
    check("R4 idle after window", alarm, 1'b0);
  endtask

  task automatic t_tick_with_key_on;
    step(1, 0, 0, 1);
    ticks(D_ON - 1);
    check("R3 tick with key-on not counted", alarm, 1'b0);
    ticks(1);
    check("R3 alarm after full count", alarm, 1'b1);
    step(0, 1, 0, 0);
  endtask

  task automatic t_abort_in_alarm;
    step(1, 0, 0, 0);
    ticks(D_ON);
    check("R5 alarm up before abort", alarm, 1'b1);
    step(0, 1, 0, 0);
    check("R5 key-off silences", alarm, 1'b0);
    ticks(D_OFF);
    check("R5 stays silent", alarm, 1'b0);
    step(1, 0, 0, 0);
    ticks(2);
    step(0, 0, 1, 0);
    ticks(D_OFF);
    check("R5 belt abort while armed", alarm, 1'b0);
  endtask

  task automatic t_abort_same_cycle;
    step(1, 0, 0, 0);
    ticks(D_ON - 1);
    step(0, 0, 1, 1);
    check("R6 abort beats expiry", alarm, 1'b0);
    ticks(D_OFF);
    check("R6 no late alarm", alarm, 1'b0);
  endtask

  task automatic t_restart;
    step(1, 0, 0, 0);
    ticks(D_ON + 1);
    check("R7 alarm up", alarm, 1'b1);
    step(1, 0, 0, 0);
    check("R7 restart drops alarm", alarm, 1'b0);
    check("R7 restart start pulse", start, 1'b1);
    ticks(D_ON - 1);
    check("R7 full delay again", alarm, 1'b0);
    ticks(1);
    check("R7 alarm after new delay", alarm, 1'b1);
    ticks(D_OFF - D_ON - 1);
    check("R7 window from new key-on", alarm, 1'b1);
    ticks(1);
    check("R7 window closes", alarm, 1'b0);
  endtask

  task automatic t_key_on_with_abort;
    step(1, 1, 0, 0);
    check("R8 no start with abort", start, 1'b0);
    ticks(D_OFF);
    check("R8 no alarm from idle", alarm, 1'b0);
    step(1, 0, 0, 0);
    ticks(2);
    step(1, 0, 1, 0);
    check("R8 no start with belt", start, 1'b0);
    ticks(D_OFF);
    check("R8 sequence aborted", alarm, 1'b0);
  endtask

  task automatic t_idle_ignore;
    step(0, 1, 1, 1);
    check("R9 idle alarm", alarm, 1'b0);
    check("R9 idle start", start, 1'b0);
    ticks(D_OFF + 3);
    check("R9 idle ticks", alarm, 1'b0);
  endtask

  task automatic t_mid_reset;
    step(1, 0, 0, 0);
    ticks(D_ON);
    check("R10 alarm before reset", alarm, 1'b1);
    rst_ni = 1'b0; #1;
    check("R10 reset drops alarm", alarm, 1'b0);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    ticks(D_OFF);
    check("R10 no alarm after reset", alarm, 1'b0);
  endtask

  initial begin
    tick = 0; kon = 0; koff = 0; belt = 0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_full_window();
    t_tick_with_key_on();
    t_abort_in_alarm();
    t_abort_same_cycle();
    t_restart();
    t_key_on_with_abort();
    t_idle_ignore();
    t_mid_reset();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule